// File: doc/BRIEF.md
# Dual-Slot CAS Latency Selector

This block chooses the fastest CAS latency that two memory modules can both run at the present bus frequency. Each slot presents a byte of supported latencies and two cycle-time bytes, which give the shortest clock period at one half step and at one full step below the slot's slowest latency. The block also receives the bus frequency in MHz. A start pulse begins the evaluation. The block then turns each cycle-time byte into a speed with a small iterative divider. It uses these speeds to drop the latencies that are too fast for the bus.

The pruned masks from the two slots are merged. The lowest latency left in the merged mask is then translated into a 3-bit code for the controller's timing register. An error flag reports that no common latency exists or that no module is fitted. A one-cycle done pulse marks the moment the code and the flag become valid. They hold their value until the next evaluation finishes. The inputs must stay stable from start until done.

Top module: `cas_latency_select`

## Requirements
- R1: After reset, done_o, busy_o and err_o are 0 and cas_code_o is 0.
- R2: A slot whose latency mask is 0xFF is treated as empty and contributes nothing. When exactly one slot is empty, the result comes from the other slot alone.
- R3: A cycle-time byte holds whole nanoseconds in bits 7:4 and tenths in bits 3:0. Its speed is the integer quotient 20000 / (10*upper + lower). If the half-step byte is nonzero and its speed is at least the bus frequency, the slot's shift becomes 1.
- R4: The full-step byte is examined only when the shift has reached 1. If the full-step byte is nonzero and its speed is at least the bus frequency, the shift becomes 2.
- R5: Let h be the index of the highest set bit of a slot's mask. The pruned mask keeps only the bits at index h - shift and above. If h is smaller than the shift, the limit is 0. A mask of 0 prunes to 0.
- R6: When both pruned masks are nonzero, they are ANDed. When only one is nonzero, that mask is used. The index of the lowest set bit of the result maps to the code as follows: 0→5, 1→5, 2→2, 3→6, 4→3, 5→7, 6→4, 7→0.
- R7: When both pruned masks are nonzero and their AND is empty, err_o is 1 and cas_code_o is 0.
- R8: When both slots are empty or both pruned masks are 0, err_o is 1 and cas_code_o is 0.
- R9: Each accepted start_i gives exactly one done_o pulse, one cycle wide. busy_o is high from the cycle after start until done. A start_i that arrives while busy_o is high is ignored.
- R10: cas_code_o and err_o change only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an evaluation |
| lat_mask_a_i | input | 8 | Supported-latency mask, slot A |
| cyc_half_a_i | input | 8 | Cycle time at one half step below the slowest latency, slot A |
| cyc_full_a_i | input | 8 | Cycle time at one full step below the slowest latency, slot A |
| lat_mask_b_i | input | 8 | Supported-latency mask, slot B |
| cyc_half_b_i | input | 8 | Cycle time at one half step below the slowest latency, slot B |
| cyc_full_b_i | input | 8 | Cycle time at one full step below the slowest latency, slot B |
| bus_mhz_i | input | BW | Bus frequency in MHz |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| cas_code_o | output | 3 | Encoded CAS latency |
| err_o | output | 1 | No common latency, or no module fitted |

## Verification
The corner that is hardest to reach is the floor of the pruning limit. It needs a mask whose top bit sits below the shift, and it needs both cycle-time checks to pass so that the shift is 2. This happens only when both speeds exceed the bus, so the stimulus pairs low-index masks with fast cycle bytes and a slow bus. The full-step byte being skipped after a failed half-step check is also hard to hit at random. Directed cases set a half-step byte that is too slow together with a full-step byte that would pass. Random runs bias the masks toward overlap and keep some slots empty, so that the intersection, single-slot and error paths all occur.

// File: rtl/cas_sel_pkg.sv
package cas_sel_pkg;
   localparam int MASK_W = 8;

   typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_WAIT, ST_FIN} cas_state_e;

   function automatic logic [2:0] lat_code(input logic [2:0] idx);
      logic [2:0] c;
      case (idx)
         3'd0, 3'd1: c = 3'd5;
         3'd2:       c = 3'd2;
         3'd3:       c = 3'd6;
         3'd4:       c = 3'd3;
         3'd5:       c = 3'd7;
         3'd6:       c = 3'd4;
         default:    c = 3'd0;
      endcase
      return c;
   endfunction

   function automatic logic [2:0] top_index(input logic [MASK_W-1:0] m);
      logic [2:0] r;
      r = '0;
      for (int i = 0; i < MASK_W; i++)
         if (m[i]) r = 3'(i);
      return r;
   endfunction

   function automatic logic [2:0] low_index(input logic [MASK_W-1:0] m);
      logic [2:0] r;
      r = '0;
      for (int i = MASK_W-1; i >= 0; i--)
         if (m[i]) r = 3'(i);
      return r;
   endfunction
endpackage

// File: rtl/cas_speed_div.sv
module cas_speed_div #(
   parameter int QW       = 15,
   parameter int DVW      = 8,
   parameter int DIVIDEND = 20000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [DVW-1:0] divisor_i,
   output logic           done_o,
   output logic [QW-1:0]  quot_o
);
   localparam int CW = $clog2(QW + 1);
   localparam int PW = QW + DVW + 1;

   logic [DVW-1:0] dv_q;
   logic [DVW-1:0] rem_q;
   logic [QW-1:0]  acc_q;
   logic [CW-1:0]  cnt_q;
   logic           run_q;
   logic [DVW:0]   trial;
   logic           fits;

   assign trial = {rem_q, acc_q[QW-1]};
   assign fits  = trial >= {1'b0, dv_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q   <= '0;
         rem_q  <= '0;
         acc_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !run_q) begin
            dv_q  <= divisor_i;
            rem_q <= '0;
            acc_q <= QW'(DIVIDEND);
            cnt_q <= CW'(QW);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? DVW'(trial - {1'b0, dv_q}) : DVW'(trial);
            acc_q <= {acc_q[QW-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quot_o = acc_q;

   p_div_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !run_q) |-> (divisor_i != '0));
   p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((PW'(quot_o) * PW'(dv_q) + PW'(rem_q) == PW'(DIVIDEND)) && (rem_q < dv_q)));
endmodule

// File: rtl/cas_prune.sv
module cas_prune
   import cas_sel_pkg::*;
(
   input  logic [MASK_W-1:0] mask_i,
   input  logic [1:0]        shift_i,
   output logic [MASK_W-1:0] pruned_o
);
   logic [2:0] h;
   logic [2:0] lim;

   always_comb begin
      h   = top_index(mask_i);
      lim = ({1'b0, h} >= {2'b0, shift_i}) ? 3'(h - 3'(shift_i)) : 3'd0;
      if (mask_i == '1 || mask_i == '0) pruned_o = '0;
      else                              pruned_o = mask_i & ({MASK_W{1'b1}} << lim);
   end
endmodule

// File: rtl/cas_merge.sv
module cas_merge
   import cas_sel_pkg::*;
(
   input  logic [MASK_W-1:0] pa_i,
   input  logic [MASK_W-1:0] pb_i,
   output logic [2:0]        code_o,
   output logic              err_o
);
   logic [MASK_W-1:0] fin;

   always_comb begin
      if (pa_i == '0)      fin = pb_i;
      else if (pb_i == '0) fin = pa_i;
      else                 fin = pa_i & pb_i;
      err_o  = (fin == '0);
      code_o = err_o ? 3'd0 : lat_code(low_index(fin));
   end
endmodule

// File: rtl/cas_latency_select.sv
module cas_latency_select
   import cas_sel_pkg::*;
#(
   parameter int BW       = 16,
   parameter int QW       = 15,
   parameter int DVW      = 8,
   parameter int DIVIDEND = 20000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [7:0]    lat_mask_a_i,
   input  logic [7:0]    cyc_half_a_i,
   input  logic [7:0]    cyc_full_a_i,
   input  logic [7:0]    lat_mask_b_i,
   input  logic [7:0]    cyc_half_b_i,
   input  logic [7:0]    cyc_full_b_i,
   input  logic [BW-1:0] bus_mhz_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [2:0]    cas_code_o,
   output logic          err_o
);
   localparam int NSLOT = 2;
   localparam int CMPW  = (BW > QW) ? BW : QW;

   if (DIVIDEND >= (1 << QW)) begin : g_bad_qw
      $error("QW too narrow for DIVIDEND");
   end
   if (DVW < 8) begin : g_bad_dvw
      $error("DVW must hold 10*15+15");
   end

   cas_state_e         st_q;
   logic [1:0]         job_q;
   logic [1:0]         shift_q [NSLOT];
   logic               dstart_q;
   logic               ddone;
   logic [QW-1:0]      quot;
   logic [MASK_W-1:0]  mask    [NSLOT];
   logic [7:0]         half    [NSLOT];
   logic [7:0]         full    [NSLOT];
   logic [MASK_W-1:0]  pruned  [NSLOT];
   logic [7:0]         sel_byte;
   logic [DVW-1:0]     divisor;
   logic               need;
   logic               slot;
   logic [2:0]         m_code;
   logic               m_err;

   assign mask[0] = lat_mask_a_i;  assign half[0] = cyc_half_a_i;  assign full[0] = cyc_full_a_i;
   assign mask[1] = lat_mask_b_i;  assign half[1] = cyc_half_b_i;  assign full[1] = cyc_full_b_i;

   assign slot     = job_q[1];
   assign sel_byte = job_q[0] ? full[slot] : half[slot];
   assign divisor  = DVW'(sel_byte[7:4]) * DVW'(10) + DVW'(sel_byte[3:0]);
   assign need     = (mask[slot] != 8'hFF) && (sel_byte != 8'h00) &&
                     (!job_q[0] || shift_q[slot] == 2'd1);

   cas_speed_div #(.QW(QW), .DVW(DVW), .DIVIDEND(DIVIDEND)) u_div (
      .clk(clk), .rst_n(rst_n), .start_i(dstart_q),
      .divisor_i(divisor), .done_o(ddone), .quot_o(quot));

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      cas_prune u_prune (.mask_i(mask[s]), .shift_i(shift_q[s]), .pruned_o(pruned[s]));
   end

   cas_merge u_merge (.pa_i(pruned[0]), .pb_i(pruned[1]), .code_o(m_code), .err_o(m_err));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         job_q      <= '0;
         shift_q[0] <= '0;
         shift_q[1] <= '0;
         dstart_q   <= 1'b0;
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         cas_code_o <= '0;
         err_o      <= 1'b0;
      end else begin
         done_o   <= 1'b0;
         dstart_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start_i) begin
               job_q      <= '0;
               shift_q[0] <= '0;
               shift_q[1] <= '0;
               busy_o     <= 1'b1;
               st_q       <= ST_PICK;
            end
            ST_PICK: if (need) begin
               dstart_q <= 1'b1;
               st_q     <= ST_WAIT;
            end else begin
               job_q <= job_q + 1'b1;
               st_q  <= (job_q == 2'd3) ? ST_FIN : ST_PICK;
            end
            ST_WAIT: if (ddone) begin
               if (CMPW'(quot) >= CMPW'(bus_mhz_i))
                  shift_q[slot] <= job_q[0] ? 2'd2 : 2'd1;
               job_q <= job_q + 1'b1;
               st_q  <= (job_q == 2'd3) ? ST_FIN : ST_PICK;
            end
            default: begin
               cas_code_o <= m_code;
               err_o      <= m_err;
               done_o     <= 1'b1;
               busy_o     <= 1'b0;
               st_q       <= ST_IDLE;
            end
         endcase
      end
   end

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (cas_code_o == 3'd0));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cas_code_o) || !$stable(err_o)) |-> done_o);
   p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_q[0] == 2'd2) |-> ($past(shift_q[0]) != 2'd0));
endmodule

// File: tb/sim_cas_latency_select.sv
module sim_cas_latency_select;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  ma = 8'hFF, ha = 0, fa = 0, mb = 8'hFF, hb = 0, fb = 0;
   logic [15:0] bus = 16'd100;
   logic        busy, done, err;
   logic [2:0]  code;
   int          checks = 0, errors = 0, dones = 0;
   int          seed_dummy;

   always #2.5 clk = ~clk;

   cas_latency_select u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .lat_mask_a_i(ma), .cyc_half_a_i(ha), .cyc_full_a_i(fa),
      .lat_mask_b_i(mb), .cyc_half_b_i(hb), .cyc_full_b_i(fb),
      .bus_mhz_i(bus), .busy_o(busy), .done_o(done),
      .cas_code_o(code), .err_o(err));

   always @(negedge clk) if (done) dones++;

   function automatic int spd(input logic [7:0] b);
      return 20000 / (int'(b[7:4]) * 10 + int'(b[3:0]));
   endfunction

   function automatic logic [7:0] ref_prune(input logic [7:0] m, h, f, input int bmhz);
      int sh, top, lim;
      if (m == 8'hFF || m == 8'h00) return 8'h00;
      sh = 0;
      if (h != 0 && spd(h) >= bmhz) begin
         sh = 1;
         if (f != 0 && spd(f) >= bmhz) sh = 2;
      end
      top = 0;
      for (int i = 0; i < 8; i++) if (m[i]) top = i;
      lim = (top >= sh) ? top - sh : 0;
      return m & (8'hFF << lim);
   endfunction

   function automatic logic [3:0] ref_out(input logic [7:0] pa, pb);
      logic [7:0] fm;
      int lo;
      logic [2:0] tbl [8];
      tbl = '{3'd5, 3'd5, 3'd2, 3'd6, 3'd3, 3'd7, 3'd4, 3'd0};
      fm = (pa == 0) ? pb : (pb == 0) ? pa : (pa & pb);
      if (fm == 0) return 4'b1_000;
      lo = 0;
      for (int i = 7; i >= 0; i--) if (fm[i]) lo = i;
      return {1'b0, tbl[lo]};
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: err/code actual %b_%0d expected %b_%0d", req, act[3], act[2:0], exp[3], exp[2:0]);
      end
   endtask

   task automatic run(input string req, input logic [7:0] a_m, a_h, a_f, b_m, b_h, b_f,
                      input int bmhz, input bit restart);
      logic [3:0] exp;
      int d0;
      @(negedge clk);
      ma = a_m; ha = a_h; fa = a_f; mb = b_m; hb = b_h; fb = b_f; bus = 16'(bmhz);
      exp = ref_out(ref_prune(a_m, a_h, a_f, bmhz), ref_prune(b_m, b_h, b_f, bmhz));
      d0 = dones;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int t = 0; t < 200 && !done; t++) @(negedge clk);
      check(req, {err, code}, exp);
      if (restart) begin
         repeat (5) @(negedge clk);
         checks++;
         if (dones - d0 != 1) begin
            errors++;
            $display("FAIL R9: done pulses actual %0d expected 1", dones - d0);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (done !== 1'b0 || busy !== 1'b0 || err !== 1'b0 || code !== 3'd0) begin
         errors++;
         $display("FAIL R1: reset outputs actual %b%b%b%0d expected 0000", done, busy, err, code);
      end
      rst_n = 1'b1;
      // R8 both absent
      run("R8", 8'hFF, 8'h50, 8'h60, 8'hFF, 8'h50, 8'h60, 100, 0);
      // R2 one absent: slot A only, mask 0x1C, 7.5ns half -> 266 >= 200: shift1
      run("R2", 8'h1C, 8'h75, 8'hA0, 8'hFF, 8'h00, 8'h00, 200, 0);
      run("R2", 8'hFF, 8'h00, 8'h00, 8'h0C, 8'h00, 8'h00, 200, 0);
      // R3 half fails (10ns -> 200 < 250): no shift
      run("R3", 8'h1C, 8'hA0, 8'h50, 8'h1C, 8'hA0, 8'h50, 250, 0);
      // R4 half passes, full passes -> shift 2
      run("R4", 8'h70, 8'h50, 8'h60, 8'h70, 8'h50, 8'h60, 133, 0);
      // R4 half zero: full ignored
      run("R4", 8'h70, 8'h00, 8'h50, 8'hFF, 8'h00, 8'h00, 133, 0);
      // R5 floor: top bit 1, shift 2
      run("R5", 8'h02, 8'h50, 8'h50, 8'h03, 8'h50, 8'h50, 100, 0);
      // R6 intersection
      run("R6", 8'h3C, 8'hA0, 8'hA0, 8'h30, 8'hA0, 8'hA0, 300, 0);
      // R7 empty intersection
      run("R7", 8'h04, 8'hA0, 8'hA0, 8'h10, 8'hA0, 8'hA0, 300, 0);
      // R6 top index 7 -> code 0
      run("R6", 8'h80, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 300, 0);
      // R9 start while busy ignored
      run("R9", 8'h1C, 8'h75, 8'h60, 8'h38, 8'h75, 8'h60, 200, 1);
      // R10 hold after done
      begin
         logic [3:0] held;
         held = {err, code};
         repeat (20) @(negedge clk);
         check("R10", {err, code}, held);
      end
      seed_dummy = $urandom(32'h5eed);
      for (int n = 0; n < 200; n++) begin
         logic [7:0] m0, m1, cyc [4];
         int b;
         m0 = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom);
         m1 = ($urandom % 6 == 0) ? 8'hFF : (($urandom % 2) ? m0 | 8'($urandom) : 8'($urandom));
         for (int k = 0; k < 4; k++)
            cyc[k] = ($urandom % 8 == 0) ? 8'h00 : {4'(2 + $urandom % 12), 4'($urandom % 10)};
         b = 50 + int'($urandom % 400);
         run("R6", m0, cyc[0], cyc[1], m1, cyc[2], cyc[3], b, 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R9: watchdog expired actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule